// File: doc/BRIEF.md
# Set-Associative LRU Tag Directory

This block models the tag side of a set-associative cache and scores each memory reference as a hit or a miss. It holds no data. It keeps only the tags, and each set keeps them ordered from the most recently used to the least recently used. Each request gives a byte address and a length. A hit moves the matching tag to the front of its set. A miss allocates on reads and writes alike: it pushes every tag back by one place, drops the oldest tag and places the new tag at the front.

A reference may run past the end of its line into the next set, wrapping from the last set to set 0. Such a reference looks up and updates both sets, one after the other, and then returns a single result. That result is a hit only when both halves hit. A reference whose last byte lands in a set that is neither its own nor the next one is illegal. It gets an error response and changes no state. A saturating counter totals the misses, and a synchronous clear input zeroes it without touching the tags.

Top module: `cache_tag_lru`

## Requirements
- R1: The directory has SETS = CACHE_BYTES / LINE_BYTES / WAYS sets. The set index is addr[OFF_W +: IDX_W], where OFF_W = log2(LINE_BYTES) and IDX_W = log2(SETS). The tag is addr >> (OFF_W + IDX_W). A reference to another byte of a resident line hits, and references to different sets do not disturb each other.
- R2: After reset every stored tag is zero, so tag 0 hits in any set. The miss count is 0, req_ready_o is 1 and rsp_valid_o is 0.
- R3: A hit on the most recent tag of a set leaves the order of that set unchanged.
- R4: A hit at position i moves that tag to position 0, and the tags at positions 0..i-1 each move back by one place.
- R5: On a miss the tag at the last position is discarded, all other tags move back by one place, the new tag goes to position 0, and the miss count increases by one.
- R6: A reference whose last byte (addr + req_len_i, where req_len_i is the byte count minus one) is in the same set gets exactly one response, with rsp_valid_o high in the cycle after acceptance.
- R7: A reference whose last byte falls in the next set ((index + 1) mod SETS) updates both sets. That set's tag is taken from the last-byte address. req_ready_o is low for the one cycle after acceptance, and one response follows two cycles after acceptance. The response is a hit only if both halves hit, and the reference adds at most one to the miss count.
- R8: A reference running from the last set into set 0 counts as adjacent and is handled as in R7.
- R9: A reference whose last-byte set is neither its own set nor the next one responds after one cycle with rsp_err_o = 1 and rsp_hit_o = 0. It updates no tags and does not change the miss count.
- R10: The miss count saturates at all ones.
- R11: cnt_clr_i zeroes the miss count on the next edge. It takes priority over a miss in the same cycle and leaves the tags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_addr_i | input | ADDR_W | Byte address of the first byte |
| req_len_i | input | LEN_W | Access length in bytes minus one |
| cnt_clr_i | input | 1 | Synchronous clear of the miss count |
| rsp_valid_o | output | 1 | Result strobe, one per request, in request order |
| rsp_hit_o | output | 1 | Reference hit |
| rsp_err_o | output | 1 | Reference was illegal |
| miss_cnt_o | output | CNT_W | Saturating miss count |

## Verification
The bench fills one set past its capacity and then revisits tags at the middle and tail positions. A design that failed to shift the tags ahead of a hit, or that evicted the wrong entry, would then report a hit where a miss is due, or the reverse. Line-crossing references are driven with both halves hitting, both missing and one of each. A design that scored each half separately would count two misses. A design that skipped the second set would miss when that line is probed again. A design that mishandled the wrap from the last set to set 0 would flag an error instead. After an illegal reference, a tag that a wrongful allocation would have evicted is probed again to confirm nothing changed. The counter is driven past saturation and then cleared in the same cycle as a miss.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SECOND = 1'b1
  } lk_state_e;
endpackage

// File: rtl/tag_set_update.sv
// Recency lookup for one set: position 0 is most recent.
module tag_set_update #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 20
) (
  input  logic [WAYS-1:0][TAG_W-1:0] set_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAYS-1:0][TAG_W-1:0] set_o
);
  int hit_pos;

  // lowest matching position wins; a miss shifts the whole set
  always_comb begin
    hit_o   = 1'b0;
    hit_pos = WAYS - 1;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (set_i[i] == tag_i) begin
        hit_o   = 1'b1;
        hit_pos = i;
      end
    end
  end

  assign set_o[0] = tag_i;
  for (genvar j = 1; j < WAYS; j++) begin : g_shift
    assign set_o[j] = (j <= hit_pos) ? set_i[j-1] : set_i[j];
  end
endmodule

// File: rtl/miss_counter.sv
module miss_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_o <= '0;
    else if (clr_i)                      cnt_o <= '0;
    else if (inc_i && cnt_o != CNT_MAX)  cnt_o <= cnt_o + CNT_W'(1);
  end

  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && !clr_i) |=> cnt_o == CNT_MAX); // R10
  AST_CNT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0); // R11
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && cnt_o != CNT_MAX) |=> cnt_o == $past(cnt_o) + CNT_W'(1)); // R5
endmodule

// File: rtl/cache_tag_lru.sv
module cache_tag_lru #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 6,
  parameter int CACHE_BYTES = 1024,
  parameter int LINE_BYTES  = 32,
  parameter int WAYS        = 4,
  parameter int CNT_W       = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              cnt_clr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_err_o,
  output logic [CNT_W-1:0]  miss_cnt_o
);
  localparam int SETS   = CACHE_BYTES / LINE_BYTES / WAYS; // must be >= 2
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int TAG_W  = LINE_W - IDX_W;

  typedef logic [WAYS-1:0][TAG_W-1:0] set_t;

  cache_tag_pkg::lk_state_e state_q;
  set_t              tags_q [SETS];
  logic [LINE_W-1:0] line_a, line_b;
  logic [IDX_W-1:0]  idx_a, idx_b, idx_next, h2_idx_q, cur_idx;
  logic [TAG_W-1:0]  tag_a, tag_b, h2_tag_q, cur_tag;
  logic              same, straddle, illegal, busy, accept, wr_en;
  logic              miss1_q, upd_hit, cnt_inc;
  set_t              cur_set, upd_set;

  // decode first and last byte lines
  assign line_a   = req_addr_i[ADDR_W-1:OFF_W];
  assign line_b   = LINE_W'((req_addr_i + ADDR_W'(req_len_i)) >> OFF_W);
  assign idx_a    = line_a[IDX_W-1:0];
  assign tag_a    = line_a[LINE_W-1:IDX_W];
  assign idx_b    = line_b[IDX_W-1:0];
  assign tag_b    = line_b[LINE_W-1:IDX_W];
  assign idx_next = idx_a + IDX_W'(1);
  assign same     = (idx_a == idx_b);
  assign straddle = !same && (idx_next == idx_b);
  assign illegal  = !same && !straddle;

  assign busy        = (state_q == cache_tag_pkg::ST_SECOND);
  assign req_ready_o = !busy;
  assign accept      = req_valid_i && !busy;

  assign cur_idx = busy ? h2_idx_q : idx_a;
  assign cur_tag = busy ? h2_tag_q : tag_a;
  assign cur_set = tags_q[cur_idx];
  assign wr_en   = busy || (accept && !illegal);

  tag_set_update #(.WAYS(WAYS), .TAG_W(TAG_W)) u_upd (
    .set_i (cur_set),
    .tag_i (cur_tag),
    .hit_o (upd_hit),
    .set_o (upd_set)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) tags_q[s] <= '0;
    end else if (wr_en) begin
      tags_q[cur_idx] <= upd_set;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= cache_tag_pkg::ST_IDLE;
      h2_idx_q    <= '0;
      h2_tag_q    <= '0;
      miss1_q     <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= (accept && !straddle) || busy;
      rsp_hit_o   <= busy ? (!miss1_q && upd_hit) : (accept && upd_hit && !illegal);
      rsp_err_o   <= accept && illegal;
      if (busy) begin
        state_q <= cache_tag_pkg::ST_IDLE;
      end else if (accept && straddle) begin
        state_q  <= cache_tag_pkg::ST_SECOND;
        h2_idx_q <= idx_b;
        h2_tag_q <= tag_b;
        miss1_q  <= !upd_hit;
      end
    end
  end

  assign cnt_inc = (accept && same && !upd_hit) || (busy && (miss1_q || !upd_hit));

  miss_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr_i),
    .inc_i  (cnt_inc),
    .cnt_o  (miss_cnt_o)
  );

  AST_SINGLE_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && same) |=> (rsp_valid_o && !rsp_err_o)); // R6
  AST_STRADDLE_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && straddle) |=> (!req_ready_o && !rsp_valid_o)); // R7
  AST_SECOND_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> (req_ready_o && rsp_valid_o)); // R7
  AST_ERR_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && illegal) |=> (rsp_valid_o && rsp_err_o && !rsp_hit_o)); // R9
  AST_ERR_NO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && illegal && !cnt_clr_i) |=> $stable(miss_cnt_o)); // R9
endmodule

// File: tb/cache_tag_lru_tb.sv
`timescale 1ns/1ps
module cache_tag_lru_tb;
  localparam int CNT_W = 4;
  localparam int CNT_MAX = 15;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic [5:0]  req_len_i = '0;
  logic        cnt_clr_i = 1'b0;
  logic        rsp_valid_o, rsp_hit_o, rsp_err_o;
  logic [CNT_W-1:0] miss_cnt_o;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;

  always #2.5 clk = ~clk;

  cache_tag_lru #(
    .ADDR_W(32), .LEN_W(6), .CACHE_BYTES(512), .LINE_BYTES(16), .WAYS(4), .CNT_W(CNT_W)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_len_i(req_len_i), .cnt_clr_i(cnt_clr_i),
    .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_err_o(rsp_err_o),
    .miss_cnt_o(miss_cnt_o)
  );

  // 16-byte lines, 8 sets: tag above bit 7, set in bits 6:4
  function automatic logic [31:0] mk(input int tag, input int set, input int off);
    return (32'(tag) << 7) | (32'(set) << 4) | 32'(off);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [31:0] a, input int len, input bit two,
                        input bit exp_hit, input bit exp_err, input string rq);
    @(negedge clk);
    chk(req_ready_o == 1'b1, rq, "ready before", int'(req_ready_o), 1);
    req_valid_i = 1'b1;
    req_addr_i  = a;
    req_len_i   = 6'(len);
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    if (two) begin
      chk(!req_ready_o && !rsp_valid_o, rq, "stall cycle ready|valid",
          int'({req_ready_o, rsp_valid_o}), 0);
      @(negedge clk);
    end
    if (!exp_hit && !exp_err) exp_cnt = (exp_cnt == CNT_MAX) ? CNT_MAX : exp_cnt + 1;
    chk(rsp_valid_o == 1'b1, rq, "rsp_valid", int'(rsp_valid_o), 1);
    chk(rsp_hit_o == exp_hit, rq, "hit", int'(rsp_hit_o), int'(exp_hit));
    chk(rsp_err_o == exp_err, rq, "err", int'(rsp_err_o), int'(exp_err));
    chk(int'(miss_cnt_o) == exp_cnt, rq, "miss count", int'(miss_cnt_o), exp_cnt);
  endtask

  task automatic t_reset();
    chk(req_ready_o == 1'b1, "R2", "ready", int'(req_ready_o), 1);
    chk(rsp_valid_o == 1'b0, "R2", "rsp_valid", int'(rsp_valid_o), 0);
    chk(miss_cnt_o == '0, "R2", "miss count", int'(miss_cnt_o), 0);
    do_req(mk(0, 3, 0), 0, 0, 1, 0, "R2");
  endtask

  task automatic t_lru();
    do_req(mk(1, 1, 0), 0, 0, 0, 0, "R5");
    do_req(mk(2, 1, 0), 0, 0, 0, 0, "R5");
    do_req(mk(3, 1, 0), 0, 0, 0, 0, "R5");
    do_req(mk(4, 1, 0), 0, 0, 0, 0, "R5");   // [4,3,2,1]
    do_req(mk(4, 1, 3), 0, 0, 1, 0, "R3");
    do_req(mk(2, 1, 0), 0, 0, 1, 0, "R4");   // [2,4,3,1]
    do_req(mk(5, 1, 0), 0, 0, 0, 0, "R5");   // [5,2,4,3]
    do_req(mk(1, 1, 0), 0, 0, 0, 0, "R5");   // [1,5,2,4]
    do_req(mk(4, 1, 0), 0, 0, 1, 0, "R4");   // [4,1,5,2]
    do_req(mk(3, 1, 0), 0, 0, 0, 0, "R4");   // [3,4,1,5]
    do_req(mk(3, 1, 9), 0, 0, 1, 0, "R1");
    do_req(mk(4, 2, 5), 0, 0, 0, 0, "R1");   // set2 [4,0,0,0]
  endtask

  task automatic t_straddle();
    do_req(mk(0, 2, 12), 7, 1, 1, 0, "R7");
    do_req(mk(6, 2, 12), 7, 1, 0, 0, "R7");  // both miss, one count
    do_req(mk(6, 3, 0), 0, 0, 1, 0, "R7");
    do_req(mk(7, 4, 14), 3, 1, 0, 0, "R7");
    do_req(mk(7, 5, 15), 1, 1, 0, 0, "R7");  // first hits, second misses
    do_req(mk(7, 5, 15), 1, 1, 1, 0, "R7");
  endtask

  task automatic t_wrap();
    do_req(mk(3, 7, 15), 1, 1, 0, 0, "R8");  // second half is tag 4, set 0
    do_req(mk(4, 0, 2), 0, 0, 1, 0, "R8");
    do_req(mk(3, 7, 0), 0, 0, 1, 0, "R8");
  endtask

  task automatic t_illegal();
    do_req(mk(0, 1, 0), 40, 0, 0, 1, "R9");  // set 1 -> set 3
    do_req(mk(5, 1, 0), 0, 0, 1, 0, "R9");   // 5 still resident in set 1
    do_req(mk(0, 7, 0), 63, 0, 0, 1, "R9");  // set 7 -> set 2
  endtask

  task automatic t_saturate();
    for (int t = 10; t < 26; t++) do_req(mk(t, 0, 0), 0, 0, 0, 0, "R10");
    chk(int'(miss_cnt_o) == CNT_MAX, "R10", "saturated count", int'(miss_cnt_o), CNT_MAX);
  endtask

  task automatic t_clear();
    @(negedge clk);
    cnt_clr_i = 1'b1;
    @(negedge clk);
    cnt_clr_i = 1'b0;
    exp_cnt = 0;
    chk(miss_cnt_o == '0, "R11", "count after clear", int'(miss_cnt_o), 0);
    do_req(mk(25, 0, 0), 0, 0, 1, 0, "R11");
    @(negedge clk);
    req_valid_i = 1'b1;
    req_addr_i  = mk(30, 0, 0);
    req_len_i   = '0;
    cnt_clr_i   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    cnt_clr_i   = 1'b0;
    chk(rsp_valid_o && !rsp_hit_o, "R11", "miss rsp during clear",
        int'({rsp_valid_o, rsp_hit_o}), 2);
    chk(miss_cnt_o == '0, "R11", "clear beats miss", int'(miss_cnt_o), 0);
    do_req(mk(31, 0, 0), 0, 0, 0, 0, "R11");
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_lru();
    t_straddle();
    t_wrap();
    t_illegal();
    t_saturate();
    t_clear();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule